// File: doc/BRIEF.md
# Interrupt Controller Command Port

This block is the register front end of an eight-line interrupt controller. Software reaches it through two byte-wide locations selected by a one-bit address. The low location accepts the word that opens a setup sequence, and also the run-time commands: mode changes, end-of-interrupt and priority rotation. The high location accepts the request mask in normal operation, and the remaining setup words while a setup sequence is open. Reads return the pending vector, the in-service vector or the mask. A poll read instead returns the winning line and acknowledges it in the same access.

The block owns the mask, vector base, nesting and auto-EOI mode bits, special-mask flag, in-service vector and rotation base, and it drives all of them to the controller core. It does not capture requests or search priorities. The core supplies the pending vector, the current winner and the highest-priority in-service line, and this port acts on them. Every access is a single-cycle strobe. Read data and the acknowledge pulse are registered and appear one cycle after the read strobe.

Top module: `icu_cmd_port`

## Requirements
- R1: While reset is low, and after it is released with no access, every output is zero: mask, vector base, mode bits, special mask, in-service vector, rotation base, read data and acknowledge.
- R2: A write to address 0 with bit 4 set clears mask, vector base, in-service vector, rotation base, nesting mode, auto-EOI, rotate-on-auto-EOI, special mask, poll and read-select (back to pending). It latches bit 0 as "fourth word needed" and bit 1 as "single", and opens the setup sequence at word 2.
- R3: At word 2, a write to address 1 loads the vector base with bits 7:3 of the data and zeros in bits 2:0. The mask is left unchanged.
- R4: After word 2, the next step is word 3 when single is clear. When single is set, it is word 4 if the fourth word is needed and normal otherwise. After word 3, the next step is word 4 if needed, else normal. A word-3 write changes no output.
- R5: A word-4 write sets nesting mode from bit 4 and auto-EOI from bit 1, then returns to normal.
- R6: In normal state, a write to address 1 loads the mask with all 8 data bits.
- R7: A write to address 0 with bit 4 clear and bit 3 set is a mode command. Bit 2 arms poll. Bit 1 set makes bit 0 the read-select (1 = in-service, 0 = pending). Bit 6 set makes bit 5 the new special-mask flag. Fields whose enable bit is clear keep their value.
- R8: A read with poll disarmed returns, one cycle later, the in-service or pending vector for address 0 (per read-select), or the mask for address 1.
- R9: A write to address 0 with bits 4:3 clear has its command code in bits 7:5. Code 1 clears the in-service bit of the highest-priority in-service line. Code 5 does the same and sets the rotation base to that line + 1 mod 8.
- R10: Code 3 clears the in-service bit of the line in bits 2:0. Code 7 does the same and sets the rotation base to that line + 1 mod 8. Code 6 sets the rotation base to bits 2:0 + 1 mod 8 and leaves the in-service vector alone.
- R11: Code 1 or 5 with an empty in-service vector changes nothing, and code 2 changes nothing.
- R12: A read with poll armed always disarms poll. With a winner, it returns 0x80 ORed with the winner's line and pulses the acknowledge output with that line, both one cycle after the strobe. With no winner, it returns 0x00 and no pulse.
- R13: A poll acknowledge sets the winner's in-service bit when auto-EOI is clear. When auto-EOI is set, it leaves the in-service vector alone, and it sets the rotation base to line + 1 mod 8 only if rotate-on-auto-EOI is on (code 4 sets it, code 0 clears it).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb_i | input | 1 | Single-cycle write strobe |
| rd_stb_i | input | 1 | Single-cycle read strobe |
| addr_i | input | 1 | Location select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data, valid the cycle after the read strobe |
| pend_i | input | 8 | Pending vector from the request capture logic |
| win_vld_i | input | 1 | Core has a winning line |
| win_line_i | input | 3 | Winning line |
| isr_top_vld_i | input | 1 | In-service vector is non-empty |
| isr_top_line_i | input | 3 | Highest-priority in-service line |
| mask_o | output | 8 | Request mask |
| vec_base_o | output | 8 | Vector base, low three bits zero |
| nest_mode_o | output | 1 | Special nested mode |
| auto_eoi_o | output | 1 | Auto end-of-interrupt mode |
| spec_mask_o | output | 1 | Special mask mode |
| isr_o | output | 8 | In-service vector |
| rot_base_o | output | 3 | Line that currently has top priority |
| ack_stb_o | output | 1 | Poll acknowledge pulse |
| ack_line_o | output | 3 | Line acknowledged by the pulse |

## Verification
A wrong setup-sequence state shows at the next write to address 1. That byte lands in the mask when it should have gone to the vector base, or the reverse, and the mask and vector outputs show the error on the following cycle. A stale poll flag shows on the very next read: a poll-style byte and an acknowledge pulse appear where a plain register read was expected. A wrong rotation base or in-service bit shows on the isr_o and rot_base_o ports right after the command that caused it. It also shows later, when a nonspecific end-of-interrupt clears a line other than the one the bench's own priority model names.

// File: rtl/icu_cmd_pkg.sv
// Shared definitions for the interrupt controller command port.
// Assumes a byte-wide data path and eight request lines.
package icu_cmd_pkg;

    localparam int unsigned DW_DEF    = 8;
    localparam int unsigned NLINE_DEF = 8;

    // Bit positions that the decoders depend on.
    localparam int unsigned B_SETUP   = 4;
    localparam int unsigned B_MODE    = 3;
    localparam int unsigned B_POLL    = 2;
    localparam int unsigned B_RSEL_EN = 1;
    localparam int unsigned B_RSEL    = 0;
    localparam int unsigned B_SMM_EN  = 6;
    localparam int unsigned B_SMM     = 5;
    localparam int unsigned B_NEED4   = 0;
    localparam int unsigned B_SINGLE  = 1;
    localparam int unsigned B_NEST    = 4;
    localparam int unsigned B_AEOI    = 1;

    // Setup sequencer position.
    typedef enum logic [1:0] {
        SEQ_RUN = 2'd0,
        SEQ_W2  = 2'd1,
        SEQ_W3  = 2'd2,
        SEQ_W4  = 2'd3
    } seq_e;

    // Command codes carried in bits 7:5.
    typedef enum logic [2:0] {
        OP_RAEOI_OFF = 3'd0,
        OP_EOI       = 3'd1,
        OP_NOP       = 3'd2,
        OP_SEOI      = 3'd3,
        OP_RAEOI_ON  = 3'd4,
        OP_REOI      = 3'd5,
        OP_SETPRI    = 3'd6,
        OP_RSEOI     = 3'd7
    } op_e;

endpackage

// File: rtl/icu_cmd_seq.sv
// Setup-word sequencer and mask / vector / mode holder.
// Opens a setup sequence on an address-0 write with the setup bit, then
// steers address-1 writes into vector base, a skipped word, or mode bits,
// and into the mask once the sequence is closed.
// Assumes single-cycle write strobes.
module icu_cmd_seq
    import icu_cmd_pkg::*;
#(
    parameter int unsigned DW    = DW_DEF,
    parameter int unsigned NLINE = NLINE_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    output logic          setup_w,
    output logic [DW-1:0] mask_q,
    output logic [DW-1:0] vec_q,
    output logic          nest_q,
    output logic          aeoi_q
);
    localparam int unsigned LW = $clog2(NLINE);

    seq_e state_q;
    logic need4_q;
    logic single_q;
    logic hi_w;

    // Decode the setup-opening write and address-1 writes.
    assign setup_w = wr_stb && !addr && wdata[B_SETUP];
    assign hi_w    = wr_stb && addr;

    // Sequencer state, flags and the registers it loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_RUN;
            need4_q  <= 1'b0;
            single_q <= 1'b0;
            mask_q   <= '0;
            vec_q    <= '0;
            nest_q   <= 1'b0;
            aeoi_q   <= 1'b0;
        end else if (setup_w) begin
            state_q  <= SEQ_W2;
            need4_q  <= wdata[B_NEED4];
            single_q <= wdata[B_SINGLE];
            mask_q   <= '0;
            vec_q    <= '0;
            nest_q   <= 1'b0;
            aeoi_q   <= 1'b0;
        end else if (hi_w) begin
            case (state_q)
                SEQ_RUN: mask_q <= wdata;
                SEQ_W2: begin
                    vec_q <= {wdata[DW-1:LW], {LW{1'b0}}};
                    if (!single_q)    state_q <= SEQ_W3;
                    else if (need4_q) state_q <= SEQ_W4;
                    else              state_q <= SEQ_RUN;
                end
                SEQ_W3: state_q <= need4_q ? SEQ_W4 : SEQ_RUN;
                SEQ_W4: begin
                    nest_q  <= wdata[B_NEST];
                    aeoi_q  <= wdata[B_AEOI];
                    state_q <= SEQ_RUN;
                end
                default: state_q <= SEQ_RUN;
            endcase
        end
    end

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_w && !setup_w) |=> $stable(mask_q)); // R6
    AST_VEC_ONLY_W2: assert property (@(posedge clk) disable iff (!rst_n)
        (!setup_w && !(hi_w && state_q == SEQ_W2)) |=> $stable(vec_q)); // R3
    AST_SINGLE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_w && state_q == SEQ_W2 && single_q && !need4_q) |=> state_q == SEQ_RUN); // R4
    AST_SETUP_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        setup_w |=> (state_q == SEQ_W2 && mask_q == '0)); // R2

endmodule

// File: rtl/icu_cmd_ocw.sv
// Run-time command decoder: mode commands, end-of-interrupt and rotation
// commands, and the in-service / rotation effect of a poll acknowledge.
// Assumes the core supplies the highest-priority in-service line and the
// current winner, both valid in the cycle of the strobe.
module icu_cmd_ocw
    import icu_cmd_pkg::*;
#(
    parameter int unsigned DW    = DW_DEF,
    parameter int unsigned NLINE = NLINE_DEF,
    localparam int unsigned LW   = $clog2(NLINE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic             rd_stb,
    input  logic             addr,
    input  logic [DW-1:0]    wdata,
    input  logic             setup_w,
    input  logic             aeoi,
    input  logic             win_vld,
    input  logic [LW-1:0]    win_line,
    input  logic             top_vld,
    input  logic [LW-1:0]    top_line,
    output logic [NLINE-1:0] isr_q,
    output logic [LW-1:0]    rot_q,
    output logic             poll_q,
    output logic             rsel_q,
    output logic             smm_q
);
    logic             raeoi_q;
    logic             lo_w;
    logic             mode_w;
    logic             cmd_w;
    logic             ack;
    op_e              op;
    logic [LW-1:0]    sel;
    logic [NLINE-1:0] clr;
    logic [NLINE-1:0] set;
    logic [LW-1:0]    rot_n;
    logic             raeoi_n;

    // Split address-0 writes into mode and command forms.
    assign lo_w   = wr_stb && !addr && !wdata[B_SETUP];
    assign mode_w = lo_w && wdata[B_MODE];
    assign cmd_w  = lo_w && !wdata[B_MODE];
    assign op     = op_e'(wdata[DW-1:DW-3]);
    assign sel    = wdata[LW-1:0];
    assign ack    = rd_stb && poll_q && win_vld;

    // Work out in-service clears/sets and the next rotation base.
    always_comb begin
        clr     = '0;
        set     = '0;
        rot_n   = rot_q;
        raeoi_n = raeoi_q;
        if (cmd_w) begin
            case (op)
                OP_RAEOI_OFF: raeoi_n = 1'b0;
                OP_RAEOI_ON:  raeoi_n = 1'b1;
                OP_EOI: begin
                    if (top_vld) clr[top_line] = 1'b1;
                end
                OP_REOI: begin
                    if (top_vld) begin
                        clr[top_line] = 1'b1;
                        rot_n         = top_line + 1'b1;
                    end
                end
                OP_SEOI: clr[sel] = 1'b1;
                OP_SETPRI: rot_n = sel + 1'b1;
                OP_RSEOI: begin
                    clr[sel] = 1'b1;
                    rot_n    = sel + 1'b1;
                end
                default: ;
            endcase
        end
        if (ack) begin
            if (!aeoi)        set[win_line] = 1'b1;
            else if (raeoi_q) rot_n = win_line + 1'b1;
        end
    end

    // In-service vector, rotation base and rotate-on-auto-EOI flag.
    always_ff @(posedge clk) begin
        if (!rst_n || setup_w) begin
            isr_q   <= '0;
            rot_q   <= '0;
            raeoi_q <= 1'b0;
        end else begin
            isr_q   <= (isr_q & ~clr) | set;
            rot_q   <= rot_n;
            raeoi_q <= raeoi_n;
        end
    end

    // Poll arm/disarm, read-select and special-mask flags.
    always_ff @(posedge clk) begin
        if (!rst_n || setup_w) begin
            poll_q <= 1'b0;
            rsel_q <= 1'b0;
            smm_q  <= 1'b0;
        end else begin
            if (mode_w && wdata[B_POLL]) poll_q <= 1'b1;
            else if (rd_stb)             poll_q <= 1'b0;
            if (mode_w && wdata[B_RSEL_EN]) rsel_q <= wdata[B_RSEL];
            if (mode_w && wdata[B_SMM_EN])  smm_q  <= wdata[B_SMM];
        end
    end

    AST_POLL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb) |=> !poll_q); // R12
    AST_SETUP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        setup_w |=> (isr_q == '0 && rot_q == '0 && !poll_q)); // R2
    AST_EOI_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && (op == OP_EOI || op == OP_REOI) && !top_vld && !rd_stb)
        |=> ($stable(isr_q) && $stable(rot_q))); // R11
    AST_AEOI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && aeoi && !wr_stb) |=> $stable(isr_q)); // R13
    AST_MODE_NO_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w && !rd_stb) |=> $stable(isr_q)); // R7

endmodule

// File: rtl/icu_cmd_rd.sv
// Registered read mux: poll byte, in-service, pending or mask, plus the
// acknowledge pulse that accompanies a successful poll.
// Assumes the winner inputs are valid in the cycle of the read strobe.
module icu_cmd_rd
#(
    parameter int unsigned DW    = 8,
    parameter int unsigned NLINE = 8,
    localparam int unsigned LW   = $clog2(NLINE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_stb,
    input  logic             addr,
    input  logic             poll,
    input  logic             rsel,
    input  logic             win_vld,
    input  logic [LW-1:0]    win_line,
    input  logic [NLINE-1:0] isr,
    input  logic [NLINE-1:0] pend,
    input  logic [DW-1:0]    mask,
    output logic [DW-1:0]    rdata_q,
    output logic             ack_q,
    output logic [LW-1:0]    ack_line_q
);
    logic [DW-1:0] mux;

    // Select the byte the current read returns.
    always_comb begin
        if (poll)       mux = win_vld ? {1'b1, {(DW-1-LW){1'b0}}, win_line} : '0;
        else if (addr)  mux = mask;
        else if (rsel)  mux = DW'(isr);
        else            mux = DW'(pend);
    end

    // Capture read data and the poll acknowledge one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q    <= '0;
            ack_q      <= 1'b0;
            ack_line_q <= '0;
        end else begin
            ack_q <= rd_stb && poll && win_vld;
            if (rd_stb) begin
                rdata_q    <= mux;
                ack_line_q <= win_line;
            end
        end
    end

    AST_ACK_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> (rdata_q[DW-1] && rdata_q[LW-1:0] == ack_line_q)); // R12
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |=> !ack_q || $past(rd_stb)); // R12

endmodule

// File: rtl/icu_cmd_port.sv
// Top of the interrupt controller command port. Ties the setup sequencer,
// the command decoder and the read mux together and exposes the programmed
// state to the controller core. Assumes single-cycle strobes and core
// inputs (pending, winner, top in-service line) valid at the strobe.
module icu_cmd_port
    import icu_cmd_pkg::*;
#(
    parameter int unsigned DW    = DW_DEF,
    parameter int unsigned NLINE = NLINE_DEF,
    localparam int unsigned LW   = $clog2(NLINE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb_i,
    input  logic             rd_stb_i,
    input  logic             addr_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o,
    input  logic [NLINE-1:0] pend_i,
    input  logic             win_vld_i,
    input  logic [LW-1:0]    win_line_i,
    input  logic             isr_top_vld_i,
    input  logic [LW-1:0]    isr_top_line_i,
    output logic [DW-1:0]    mask_o,
    output logic [DW-1:0]    vec_base_o,
    output logic             nest_mode_o,
    output logic             auto_eoi_o,
    output logic             spec_mask_o,
    output logic [NLINE-1:0] isr_o,
    output logic [LW-1:0]    rot_base_o,
    output logic             ack_stb_o,
    output logic [LW-1:0]    ack_line_o
);
    logic setup_w;
    logic poll;
    logic rsel;

    icu_cmd_seq #(.DW(DW), .NLINE(NLINE)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb_i),
        .addr    (addr_i),
        .wdata   (wdata_i),
        .setup_w (setup_w),
        .mask_q  (mask_o),
        .vec_q   (vec_base_o),
        .nest_q  (nest_mode_o),
        .aeoi_q  (auto_eoi_o)
    );

    icu_cmd_ocw #(.DW(DW), .NLINE(NLINE)) u_ocw (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb_i),
        .rd_stb   (rd_stb_i),
        .addr     (addr_i),
        .wdata    (wdata_i),
        .setup_w  (setup_w),
        .aeoi     (auto_eoi_o),
        .win_vld  (win_vld_i),
        .win_line (win_line_i),
        .top_vld  (isr_top_vld_i),
        .top_line (isr_top_line_i),
        .isr_q    (isr_o),
        .rot_q    (rot_base_o),
        .poll_q   (poll),
        .rsel_q   (rsel),
        .smm_q    (spec_mask_o)
    );

    icu_cmd_rd #(.DW(DW), .NLINE(NLINE)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_stb     (rd_stb_i),
        .addr       (addr_i),
        .poll       (poll),
        .rsel       (rsel),
        .win_vld    (win_vld_i),
        .win_line   (win_line_i),
        .isr        (isr_o),
        .pend       (pend_i),
        .mask       (mask_o),
        .rdata_q    (rdata_o),
        .ack_q      (ack_stb_o),
        .ack_line_q (ack_line_o)
    );

    AST_ISR_CLR_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stb_i && !rd_stb_i) |=> ($stable(isr_o) && $stable(rot_base_o))); // R9
    AST_NO_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb_i |=> !ack_stb_o); // R12

endmodule

// File: tb/sim_icu_cmd_port.sv
// Scoreboard bench: read tasks queue the expected byte, a monitor compares
// it the cycle after the strobe; direct port checks cover programmed state.
module sim_icu_cmd_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0, rd_stb = 1'b0, addr = 1'b0;
    logic [7:0] wdata = '0, rdata, pend = '0;
    logic       win_vld = 1'b0;
    logic [2:0] win_line = '0;
    logic       top_vld;
    logic [2:0] top_line;
    logic [7:0] mask, vec, isr;
    logic       nest, aeoi, smm, ack;
    logic [2:0] rot, ack_line;

    int n_chk = 0, n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_d = 1'b0;

    always #2.5 clk = ~clk;

    // Core model of the in-service priority search, from the port outputs.
    function automatic logic [3:0] top_of(logic [7:0] v, logic [2:0] r);
        for (int k = 0; k < 8; k++) begin
            logic [2:0] idx = r + 3'(k);
            if (v[idx]) return {1'b1, idx};
        end
        return 4'd0;
    endfunction
    assign {top_vld, top_line} = top_of(isr, rot);

    icu_cmd_port u0 (
        .clk(clk), .rst_n(rst_n), .wr_stb_i(wr_stb), .rd_stb_i(rd_stb),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pend_i(pend),
        .win_vld_i(win_vld), .win_line_i(win_line),
        .isr_top_vld_i(top_vld), .isr_top_line_i(top_line),
        .mask_o(mask), .vec_base_o(vec), .nest_mode_o(nest),
        .auto_eoi_o(aeoi), .spec_mask_o(smm), .isr_o(isr),
        .rot_base_o(rot), .ack_stb_o(ack), .ack_line_o(ack_line)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); wr_stb = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic rd(input logic a, input logic [7:0] exp, input string req);
        exp_q.push_back(exp); tag_q.push_back(req);
        @(negedge clk); rd_stb = 1'b1; addr = a;
        @(negedge clk); rd_stb = 1'b0;
    endtask

    // Poll read of a given winner: arm, read, check byte, pulse and line.
    task automatic poll_ack(input logic [2:0] line, input string req);
        wr(1'b0, 8'h0C);
        win_vld = 1'b1; win_line = line;
        rd(1'b0, {5'b10000, line}, req);
        chk({7'd0, ack}, 8'd1, req);
        chk({5'd0, ack_line}, {5'd0, line}, req);
        win_vld = 1'b0;
    endtask

    // Record when read data is due.
    always @(posedge clk) rd_d <= rd_stb;

    // Monitor: compare read data against the queued expectation.
    always @(negedge clk) begin
        if (rd_d) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R8: actual=%02h expected=none", rdata);
            end else begin
                chk(rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mask, 8'h00, "R1"); chk(vec, 8'h00, "R1"); chk(isr, 8'h00, "R1");
        chk({nest, aeoi, smm, ack, 1'b0, rot}, 8'h00, "R1"); chk(rdata, 8'h00, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk(mask, 8'h00, "R1");
        rd(1'b1, 8'h00, "R1");

        // Cascade, fourth word needed: W2, W3, W4
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h45); chk(vec, 8'h40, "R3"); chk(mask, 8'h00, "R3");
        wr(1'b1, 8'h04); chk(mask, 8'h00, "R4"); chk(vec, 8'h40, "R4");
        wr(1'b1, 8'h12); chk({6'd0, nest, aeoi}, 8'h03, "R5");
        wr(1'b1, 8'hA5); chk(mask, 8'hA5, "R6");

        // Single with fourth word: W2 then W4 (R2 clears on reopen)
        wr(1'b0, 8'h13);
        chk(mask, 8'h00, "R2"); chk({6'd0, nest, aeoi}, 8'h00, "R2"); chk(vec, 8'h00, "R2");
        wr(1'b1, 8'h28); chk(vec, 8'h28, "R3");
        wr(1'b1, 8'h02); chk({6'd0, nest, aeoi}, 8'h01, "R4"); chk(mask, 8'h00, "R4");
        wr(1'b1, 8'h3C); chk(mask, 8'h3C, "R6");

        // Single without fourth word: W2 only
        wr(1'b0, 8'h12);
        wr(1'b1, 8'h77); chk(vec, 8'h70, "R3");
        wr(1'b1, 8'h0F); chk(mask, 8'h0F, "R4"); chk({7'd0, aeoi}, 8'h00, "R4");

        // Cascade without fourth word: W2, W3
        wr(1'b0, 8'h10);
        wr(1'b1, 8'h08); chk(vec, 8'h08, "R3");
        wr(1'b1, 8'h99); chk(mask, 8'h00, "R4");
        wr(1'b1, 8'h55); chk(mask, 8'h55, "R4");
        rd(1'b1, 8'h55, "R8");

        // Poll with winner, then disarmed plain read
        pend = 8'h3A;
        poll_ack(3'd5, "R12");
        chk(isr, 8'h20, "R13");
        rd(1'b0, 8'h3A, "R12");
        chk({7'd0, ack}, 8'h00, "R12");
        // Poll with no winner
        wr(1'b0, 8'h0C);
        rd(1'b0, 8'h00, "R12");
        chk({7'd0, ack}, 8'h00, "R12"); chk(isr, 8'h20, "R12");
        rd(1'b0, 8'h3A, "R12");

        // Read-select and special mask
        poll_ack(3'd1, "R13");
        wr(1'b0, 8'h0B); rd(1'b0, 8'h22, "R7");
        wr(1'b0, 8'h09); rd(1'b0, 8'h22, "R7");
        wr(1'b0, 8'h0A); rd(1'b0, 8'h3A, "R8");
        wr(1'b0, 8'h68); chk({7'd0, smm}, 8'h01, "R7");
        wr(1'b0, 8'h28); chk({7'd0, smm}, 8'h01, "R7");
        wr(1'b0, 8'h48); chk({7'd0, smm}, 8'h00, "R7");

        // Nonspecific EOI, plain and rotating
        wr(1'b0, 8'h20); chk(isr, 8'h20, "R9");
        wr(1'b0, 8'hA0); chk(isr, 8'h00, "R9"); chk({5'd0, rot}, 8'h06, "R9");

        // Empty in-service and code 2: no change
        wr(1'b0, 8'h20); chk(isr, 8'h00, "R11"); chk({5'd0, rot}, 8'h06, "R11");
        wr(1'b0, 8'hA0); chk({5'd0, rot}, 8'h06, "R11");
        poll_ack(3'd3, "R13"); poll_ack(3'd7, "R13");
        chk(isr, 8'h88, "R13");
        wr(1'b0, 8'h45); chk(isr, 8'h88, "R11"); chk({5'd0, rot}, 8'h06, "R11");

        // Specific EOI and set-priority
        wr(1'b0, 8'h67); chk(isr, 8'h08, "R10");
        wr(1'b0, 8'hE3); chk(isr, 8'h00, "R10"); chk({5'd0, rot}, 8'h04, "R10");
        wr(1'b0, 8'hC5); chk({5'd0, rot}, 8'h06, "R10");
        wr(1'b0, 8'hC7); chk({5'd0, rot}, 8'h00, "R10");

        // Nonspecific EOI under a rotated base
        poll_ack(3'd0, "R13"); poll_ack(3'd7, "R13");
        wr(1'b0, 8'hC6); chk({5'd0, rot}, 8'h07, "R10"); chk(isr, 8'h81, "R10");
        wr(1'b0, 8'h20); chk(isr, 8'h01, "R9");
        wr(1'b0, 8'h20); chk(isr, 8'h00, "R9");

        // Reopen setup clears everything, including read-select
        wr(1'b0, 8'h0B);
        poll_ack(3'd6, "R13"); chk(isr, 8'h40, "R13");
        wr(1'b0, 8'h13);
        chk(isr, 8'h00, "R2"); chk({5'd0, rot}, 8'h00, "R2");
        rd(1'b0, 8'h3A, "R2");
        wr(1'b1, 8'h00); wr(1'b1, 8'h02); chk({7'd0, aeoi}, 8'h01, "R5");

        // Auto-EOI with and without rotation
        wr(1'b0, 8'h80);
        poll_ack(3'd4, "R13");
        chk(isr, 8'h00, "R13"); chk({5'd0, rot}, 8'h05, "R13");
        wr(1'b0, 8'h00);
        poll_ack(3'd2, "R13");
        chk(isr, 8'h00, "R13"); chk({5'd0, rot}, 8'h05, "R13");

        repeat (3) @(negedge clk);
        chk(8'(exp_q.size()), 8'h00, "R8");
        finish_up();
    end
endmodule